// File: doc/BRIEF.md
# Page buffer write commit controller

This block sits between a serial-bus front-end and a byte-wide storage array. The front-end hands it a starting word address and then a stream of data bytes. The bytes are gathered in a 64-entry page buffer, with a record of which entries were filled. When the front-end signals the end of the transfer, the block either programs the filled entries into the array or throws them away. The choice depends on the level of the write-protect input at that moment.

While it programs the array, the block holds a busy flag for a fixed, parameterised number of clock cycles and ignores the front-end. It keeps the word address pointer current throughout. Only the low six pointer bits advance as bytes arrive, so a burst that runs past the end of a page folds back to the start of the same page and replaces bytes taken earlier. If several strobes arrive in one cycle, an address load wins over a data byte, and a data byte wins over a stop.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy and mem_we are low and cur_ptr is zero.
- R2: An accepted address load sets cur_ptr to ld_addr on the next cycle and forgets every byte buffered before it, so none of those bytes is written at the next commit.
- R3: Each accepted byte is stored at buffer offset cur_ptr[5:0]. cur_ptr[5:0] then increments modulo 64 and cur_ptr[13:6] is unchanged, so offset 63 is followed by offset 0 of the same page.
- R4: When more than 64 bytes arrive before a stop, each location receives the last byte sent to it and is written only once during the commit.
- R5: A stop taken with wp low and at least one buffered byte raises busy on the next cycle and holds it for exactly WRITE_CYCLES cycles.
- R6: During a commit, mem_we pulses once for each buffer offset that received a byte, in ascending offset order from 0. The writes occur within the first 64 busy cycles, with mem_addr = {cur_ptr[13:6], offset} and mem_wdata = the stored byte. Offsets that received no byte are not written.
- R7: A stop taken with wp high causes no array write and leaves busy low, at any address from 0x0000 to 0x3FFF. The buffered bytes are dropped, so a following stop with wp low writes nothing.
- R8: wp is looked at only in the cycle of the stop. Changing it while busy is high neither stops nor changes the commit under way.
- R9: While busy is high, address loads, data bytes and stops are ignored. cur_ptr does not move, and nothing offered then is written later.
- R10: After a commit, cur_ptr still holds the location after the last byte received, taken within the page.
- R11: A stop with no byte buffered since the last address load, commit or discard leaves busy low and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Address load strobe |
| ld_addr | input | 14 | Word address to load |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| stop_pulse | input | 1 | End-of-transfer strobe |
| wp | input | 1 | Write protect, high blocks the commit |
| busy | output | 1 | Commit in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 14 | Array write address |
| mem_wdata | output | 8 | Array write data |
| cur_ptr | output | 14 | Current word address pointer |

## Verification
Bursts of different sizes are committed and compared with a scoreboard. A short run from the middle of a page shows that writes come out in order. A run that crosses offset 63 separates a wrap inside the page from a carry into the next page. A run of 70 bytes shows that overwritten entries appear once, with their last value. Stops with wp high, with an empty buffer and after a reload show whether stale entries leak into a commit. Toggling wp and offering loads, bytes and stops during busy shows whether the commit depends on anything that happens after the stop.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic {CM_IDLE = 1'b0, CM_BUSY = 1'b1} cm_state_e;
endpackage

// File: rtl/pc_ptr.sv
// Word address pointer; only the in-page offset advances on a byte.
module pc_ptr #(
  parameter int ADDR_W = 14,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [OFF_W-1:0]  off_inc;

  assign off_inc = ptr_q[OFF_W-1:0] + OFF_W'(1);

  always_comb begin
    ptr_d = ptr_q;
    if (ld)       ptr_d = ld_addr;
    else if (adv) ptr_d = {ptr_q[ADDR_W-1:OFF_W], off_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/pc_buf.sv
// Page buffer with a per-entry filled mask.
module pc_buf
  import page_commit_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int OFF_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  byte_t            wr_data,
  input  logic             clr,
  input  logic [OFF_W-1:0] rd_off,
  output byte_t            rd_data,
  output logic             rd_valid,
  output logic             any_valid
);
  byte_t                 ent_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_d;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_off == OFF_W'(g));
    always_ff @(posedge clk) begin
      if (ent_en) ent_q[g] <= wr_data;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (clr)        mask_d = '0;
    else if (wr_en) mask_d[wr_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign rd_data   = ent_q[rd_off];
  assign rd_valid  = mask_q[rd_off];
  assign any_valid = |mask_q;
endmodule

// File: rtl/pc_seq.sv
// Commit sequencer: samples write protect at the stop, scans the page, times busy.
module pc_seq
  import page_commit_pkg::*;
#(
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 72,
  parameter int OFF_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_acc,
  input  logic             wp,
  input  logic             any_valid,
  input  logic             rd_valid,
  output logic             busy,
  output logic [OFF_W-1:0] scan_off,
  output logic             we,
  output logic             finish,
  output logic             discard
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  cm_state_e  st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             scanning;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    finish  = 1'b0;
    discard = 1'b0;
    case (st_q)
      CM_IDLE: begin
        if (stop_acc) begin
          if (wp) begin
            discard = 1'b1;
          end else if (any_valid) begin
            st_d  = CM_BUSY;
            cnt_d = '0;
          end
        end
      end
      CM_BUSY: begin
        if (cnt_q == CNT_W'(WRITE_CYCLES - 1)) begin
          st_d   = CM_IDLE;
          finish = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = CM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CM_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy     = (st_q == CM_BUSY);
  assign scanning = busy && (cnt_q < CNT_W'(PAGE_BYTES));
  assign scan_off = cnt_q[OFF_W-1:0];
  assign we       = scanning && rd_valid;
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import page_commit_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              stop_pulse,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] cur_ptr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic       rst_meta_q, rst_sync_n;
  logic       ld_acc, byte_acc, stop_acc;
  logic       finish, discard, rd_valid, any_valid;
  logic [OFF_W-1:0] scan_off;
  byte_t      rd_data;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Front-end strobes are dropped while busy; load > byte > stop.
  assign ld_acc   = !busy && ld_valid;
  assign byte_acc = !busy && byte_valid && !ld_valid;
  assign stop_acc = !busy && stop_pulse && !ld_valid && !byte_valid;

  pc_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .ld(ld_acc), .ld_addr(ld_addr),
    .adv(byte_acc), .ptr(cur_ptr)
  );

  pc_buf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(byte_acc),
    .wr_off(cur_ptr[OFF_W-1:0]), .wr_data(byte_data),
    .clr(ld_acc | finish | discard), .rd_off(scan_off),
    .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
  );

  pc_seq #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES), .OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .stop_acc(stop_acc), .wp(wp),
    .any_valid(any_valid), .rd_valid(rd_valid), .busy(busy),
    .scan_off(scan_off), .we(mem_we), .finish(finish), .discard(discard)
  );

  assign mem_addr  = {cur_ptr[ADDR_W-1:OFF_W], scan_off};
  assign mem_wdata = rd_data;
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
  parameter int ADDR_W       = 14,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              byte_valid,
  input logic              stop_pulse,
  input logic              wp,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] cur_ptr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [15:0] blen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen_q <= '0;
    else if (busy) blen_q <= blen_q + 16'd1;
    else           blen_q <= '0;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !busy) |=> (cur_ptr == $past(ld_addr)));

  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !ld_valid && !busy) |=>
      (cur_ptr[ADDR_W-1:OFF_W] == $past(cur_ptr[ADDR_W-1:OFF_W])) &&
      (cur_ptr[OFF_W-1:0] == OFF_W'($past(cur_ptr[OFF_W-1:0]) + 1'b1)));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (blen_q == 16'(WRITE_CYCLES)));

  p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_pulse && !wp));

  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && (mem_addr[ADDR_W-1:OFF_W] == cur_ptr[ADDR_W-1:OFF_W])));

  p_prot_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && wp && !busy && !ld_valid && !byte_valid) |=> !busy);

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_ptr));
endmodule

bind page_commit_ctrl page_commit_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
  .byte_valid(byte_valid), .stop_pulse(stop_pulse), .wp(wp), .busy(busy),
  .mem_we(mem_we), .mem_addr(mem_addr), .cur_ptr(cur_ptr)
);

// File: tb/tb_page_commit_ctrl.sv
`timescale 1ns/1ps
module tb_page_commit_ctrl;
  localparam int AW = 14;
  localparam int PB = 64;
  localparam int WC = 72;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid, byte_valid, stop_pulse, wp;
  logic [AW-1:0] ld_addr;
  logic [7:0]    byte_data;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr, cur_ptr;
  logic [7:0]    mem_wdata;

  always #2.5 clk = ~clk;

  page_commit_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_pulse(stop_pulse),
    .wp(wp), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_ptr(cur_ptr)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int cyc   = 0;

  logic [AW+7:0] sb [$];
  logic [AW-1:0] m_ptr;
  logic [7:0]    m_data [PB];
  logic [PB-1:0] m_mask;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  // Monitor: every array write must match the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6 unexpected write", int'({mem_addr, mem_wdata}), 0);
      end else begin
        logic [AW+7:0] e;
        e = sb.pop_front();
        check({mem_addr, mem_wdata} == e, "R6/R4 write", int'({mem_addr, mem_wdata}), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic load(input logic [AW-1:0] a);
    @(negedge clk); ld_valid = 1'b1; ld_addr = a;
    @(negedge clk); ld_valid = 1'b0;
    m_ptr = a; m_mask = '0;
    check(cur_ptr == a, "R2 load", int'(cur_ptr), int'(a));
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
    m_data[m_ptr[5:0]] = d;
    m_mask[m_ptr[5:0]] = 1'b1;
    m_ptr[5:0] = m_ptr[5:0] + 6'd1;
  endtask

  task automatic do_stop(input bit wpv, input bit disturb, input string tag);
    bit exp_busy;
    int n;
    exp_busy = !wpv && (m_mask != '0);
    if (exp_busy)
      for (int i = 0; i < PB; i++)
        if (m_mask[i]) sb.push_back({m_ptr[AW-1:6], 6'(i), m_data[i]});
    @(negedge clk); stop_pulse = 1'b1; wp = wpv;
    @(negedge clk); stop_pulse = 1'b0;
    if (exp_busy) begin
      n = 0;
      while (busy && n < 1000) begin
        n++;
        if (disturb) begin
          if (n == 5)  wp = ~wp;
          if (n == 10) begin ld_valid = 1'b1; ld_addr = 14'h2222; end
          if (n == 11) begin ld_valid = 1'b0; byte_valid = 1'b1; byte_data = 8'h5A; end
          if (n == 12) begin byte_valid = 1'b0; stop_pulse = 1'b1; end
          if (n == 13) stop_pulse = 1'b0;
        end
        @(negedge clk);
      end
      wp = 1'b0;
      check(n == WC, {tag, " R5 busy length"}, n, WC);
      check(sb.size() == 0, {tag, " R6 all writes seen"}, sb.size(), 0);
      check(cur_ptr == m_ptr, {tag, " R10 pointer after commit"}, int'(cur_ptr), int'(m_ptr));
    end else begin
      check(busy == 1'b0, {tag, " no busy"}, int'(busy), 0);
      repeat (3) @(negedge clk);
      check(busy == 1'b0, {tag, " still idle"}, int'(busy), 0);
      wp = 1'b0;
    end
    m_mask = '0;
  endtask

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; byte_valid = 1'b0; stop_pulse = 1'b0;
    wp = 1'b0; ld_addr = '0; byte_data = '0; m_ptr = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_we && cur_ptr == '0, "R1 in reset", int'({busy, mem_we, cur_ptr}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !mem_we && cur_ptr == '0, "R1 after reset", int'({busy, mem_we, cur_ptr}), 0);

    // Short burst mid-page
    load(14'h0123);
    for (int i = 0; i < 3; i++) send(8'hA0 + 8'(i));
    check(cur_ptr == 14'h0126, "R3 advance", int'(cur_ptr), 'h126);
    do_stop(1'b0, 1'b0, "mid");

    // Crossing offset 63 stays in the page
    load(14'h3FFE);
    for (int i = 0; i < 4; i++) send(8'h10 + 8'(i));
    check(cur_ptr == 14'h3FC2, "R3 wrap in page", int'(cur_ptr), 'h3FC2);
    do_stop(1'b0, 1'b0, "wrap");

    // 70 bytes: first six overwritten
    load(14'h0200);
    for (int i = 0; i < 70; i++) send(8'(i * 3 + 1));
    check(cur_ptr == 14'h0206, "R4 pointer after 70", int'(cur_ptr), 'h206);
    do_stop(1'b0, 1'b0, "R4 overflow");

    // Protected stop, then unprotected stop writes nothing
    load(14'h3FC0);
    send(8'h77); send(8'h78);
    do_stop(1'b1, 1'b0, "R7 protected");
    do_stop(1'b0, 1'b0, "R7 discarded");
    check(cur_ptr == 14'h3FC2, "R7 pointer kept", int'(cur_ptr), 'h3FC2);

    // Empty buffer
    load(14'h0400);
    do_stop(1'b0, 1'b0, "R11 empty");

    // wp toggled and strobes offered during busy
    load(14'h0800);
    for (int i = 0; i < 5; i++) send(8'hC0 + 8'(i));
    do_stop(1'b0, 1'b1, "R8 R9 disturbed");
    check(cur_ptr == 14'h0805, "R9 pointer ignored load", int'(cur_ptr), 'h805);
    do_stop(1'b0, 1'b0, "R9 no late bytes");

    // Reload forgets earlier bytes
    load(14'h0300);
    send(8'h11); send(8'h22);
    load(14'h0310);
    send(8'h33);
    do_stop(1'b0, 1'b0, "R2 reload");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule